// File: doc/BRIEF.md
# Dual Decade Ripple Counter

The block holds two identical decimal counters. Each one is built from a toggle stage that divides by two and a modulo-five stage that divides by five. Each stage has its own clock pin and advances on the falling edge of that clock. Each decade has its own asynchronous, active-high clear. While the clear is high it overrides both clocks of that decade and holds its four outputs low. The other decade is not affected.

A static strap per decade selects how the two stages are linked. In BCD linking, the external clock drives the toggle stage and the toggle output clocks the modulo-five stage, so the four outputs count from 0 to 9 in binary. In bi-quinary linking, the external clock drives the modulo-five stage and its top bit clocks the toggle stage. The toggle output then becomes a square wave at one tenth of the input rate, with equal high and low times. An output of one decade can be wired to a clock input of the other, giving ratios of 2, 4, 5, 10, 20, 25, 50 or 100. The strap may change only while the decade is held in clear.

Top module: `dual_decade_counter`

## Requirements
- R1: The toggle stage output Q0, bit 4d+0 of q_o, inverts on each falling edge of its stage clock. In BCD linking it therefore alternates on each falling edge of cp0_i[d].
- R2: The modulo-five stage outputs {Q3,Q2,Q1}, bits 4d+3..4d+1 of q_o, step 0,1,2,3,4 and then return to 0 on each falling edge of its stage clock. Q3 is high for one stage clock in five.
- R3: While mr_i[d] is high, the four outputs of decade d are 0 whatever its clocks do, and they stay 0 after mr_i[d] falls until the next effective falling edge.
- R4: A clear of one decade leaves the count of the other decade unchanged.
- R5: With bq_mode_i[d]=0 (BCD), the 4-bit value q_o[4d+3:4d] counts 0..9 in binary on falling edges of cp0_i[d] and wraps from 9 to 0. Q3 is high only at counts 8 and 9. cp1_i[d] has no effect.
- R6: With bq_mode_i[d]=1 (bi-quinary), falling edges of cp1_i[d] drive the modulo-five stage and each fall of Q3 toggles Q0. Q0 is high for 5 and low for 5 of every 10 input edges. cp0_i[d] has no effect.
- R7: A rising clock edge never changes any output.
- R8: When Q0 of decade 0, running in bi-quinary linking, drives cp0_i[1] of decade 1, running in BCD linking, decade 1 advances once per 10 input edges. After 100 input edges both decades return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cp0_i | input | N_DEC | Per-decade clock pin of the toggle stage (falling edge) |
| cp1_i | input | N_DEC | Per-decade clock pin of the modulo-five stage (falling edge) |
| mr_i | input | N_DEC | Per-decade asynchronous clear, active high |
| bq_mode_i | input | N_DEC | Per-decade link strap: 0 BCD, 1 bi-quinary |
| q_o | output | 4*N_DEC | Outputs of decade d at bits 4d+3..4d, as {Q3,Q2,Q1,Q0} |

## Verification
The bench builds the block with its default N_DEC=2. Two decades are what make the independence of the two clears observable, and they allow one decade to be externally chained into the other for the divide-by-100 path. With one decade in each linking mode, the same run covers the BCD and bi-quinary sequences side by side, the inputs each mode must ignore, and the ripple hand-off from a bi-quinary decade into a BCD decade.

// File: rtl/ripple_dec_pkg.sv
package ripple_dec_pkg;
  localparam int unsigned Q5_W  = 3;
  localparam int unsigned Q5_MOD = 5;
  localparam int unsigned DEC_W = Q5_W + 1;

  typedef enum logic {
    LINK_BCD = 1'b0,
    LINK_BIQ = 1'b1
  } link_mode_e;
endpackage

// File: rtl/div2_stage.sv
module div2_stage (
  input  logic clk_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(negedge clk_i or posedge clr_i) begin
    if (clr_i) q_o <= 1'b0;
    else       q_o <= ~q_o;
  end
endmodule

// File: rtl/div5_stage.sv
module div5_stage #(
  parameter int unsigned W   = 3,
  parameter int unsigned MOD = 5
) (
  input  logic         clk_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  always_ff @(negedge clk_i or posedge clr_i) begin
    if (clr_i)             q_o <= '0;
    else if (q_o == LAST)  q_o <= '0;
    else                   q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/decade_unit.sv
module decade_unit
  import ripple_dec_pkg::*;
(
  input  logic             cp0_i,
  input  logic             cp1_i,
  input  logic             mr_i,
  input  link_mode_e       mode_i,
  output logic [DEC_W-1:0] q_o
);
  logic            q0;
  logic [Q5_W-1:0] q5;
  logic            clk2, clk5;

  // strap-selected clock routing; mode is static while counting
  assign clk2 = (mode_i == LINK_BIQ) ? q5[Q5_W-1] : cp0_i;
  assign clk5 = (mode_i == LINK_BIQ) ? cp1_i      : q0;

  div2_stage u_div2 (
    .clk_i (clk2),
    .clr_i (mr_i),
    .q_o   (q0)
  );

  div5_stage #(.W(Q5_W), .MOD(Q5_MOD)) u_div5 (
    .clk_i (clk5),
    .clr_i (mr_i),
    .q_o   (q5)
  );

  assign q_o = {q5, q0};
endmodule

// File: rtl/dual_decade_counter.sv
module dual_decade_counter
  import ripple_dec_pkg::*;
#(
  parameter int unsigned N_DEC = 2
) (
  input  logic [N_DEC-1:0]       cp0_i,
  input  logic [N_DEC-1:0]       cp1_i,
  input  logic [N_DEC-1:0]       mr_i,
  input  logic [N_DEC-1:0]       bq_mode_i,
  output logic [DEC_W*N_DEC-1:0] q_o
);
  for (genvar d = 0; d < N_DEC; d++) begin : g_dec
    decade_unit u_dec (
      .cp0_i  (cp0_i[d]),
      .cp1_i  (cp1_i[d]),
      .mr_i   (mr_i[d]),
      .mode_i (link_mode_e'(bq_mode_i[d])),
      .q_o    (q_o[DEC_W*d +: DEC_W])
    );
  end
endmodule

// File: rtl/dual_decade_counter_chk.sv
module dual_decade_counter_chk #(
  parameter int unsigned N_DEC = 2
) (
  input logic [N_DEC-1:0]   cp0_i,
  input logic [N_DEC-1:0]   cp1_i,
  input logic [N_DEC-1:0]   mr_i,
  input logic [N_DEC-1:0]   bq_mode_i,
  input logic [4*N_DEC-1:0] q_o
);
  for (genvar d = 0; d < N_DEC; d++) begin : g_chk
    // R5: BCD value never leaves 0..9
    p_bcd_range_r5: assert property (@(negedge cp0_i[d]) disable iff (mr_i[d] || bq_mode_i[d])
      q_o[4*d +: 4] <= 4'd9);

    // R2: modulo-five field never leaves 0..4 in bi-quinary linking
    p_div5_range_r2: assert property (@(negedge cp1_i[d]) disable iff (mr_i[d] || !bq_mode_i[d])
      q_o[4*d+1 +: 3] <= 3'd4);

    // R3: clear overrides the toggle-stage clock pin
    always_ff @(negedge cp0_i[d]) begin
      if (mr_i[d]) p_clr_over_cp0_r3: assert (q_o[4*d +: 4] == 4'd0);
    end

    // R3: clear overrides the modulo-five clock pin
    always_ff @(negedge cp1_i[d]) begin
      if (mr_i[d]) p_clr_over_cp1_r3: assert (q_o[4*d +: 4] == 4'd0);
    end
  end
endmodule

bind dual_decade_counter dual_decade_counter_chk #(.N_DEC(N_DEC)) u_chk (
  .cp0_i     (cp0_i),
  .cp1_i     (cp1_i),
  .mr_i      (mr_i),
  .bq_mode_i (bq_mode_i),
  .q_o       (q_o)
);

// File: tb/sim_dual_decade_counter.sv
`timescale 1ns/1ps
module sim_dual_decade_counter;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] cp0_drv = 2'b00;
  logic [1:0] cp1_i   = 2'b00;
  logic [1:0] mr_i    = 2'b11;
  logic [1:0] bq_mode_i = 2'b00;
  logic       chain   = 1'b0;
  logic [7:0] q_o;
  logic [1:0] cp0_i;

  assign cp0_i = {chain ? q_o[0] : cp0_drv[1], cp0_drv[0]};

  dual_decade_counter #(.N_DEC(2)) u0 (
    .cp0_i(cp0_i), .cp1_i(cp1_i), .mr_i(mr_i), .bq_mode_i(bq_mode_i), .q_o(q_o)
  );

  int n_chk = 0, n_fail = 0;
  int cnt [2] = '{0, 0};
  int cyc = 0;

  function automatic logic [3:0] exp_q(int d);
    if (bq_mode_i[d]) return {3'(cnt[d] % 5), 1'((cnt[d] / 5) % 2)};
    return 4'(cnt[d]);
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " d0"}, q_o[3:0], exp_q(0));
    chk({tag, " d1"}, q_o[7:4], exp_q(1));
  endtask

  task automatic advance(int d);
    logic old_q0;
    old_q0 = exp_q(d)[0];
    cnt[d] = (cnt[d] + 1) % 10;
    if (chain && d == 0 && old_q0 && !exp_q(0)[0] && !bq_mode_i[1]) cnt[1] = (cnt[1] + 1) % 10;
  endtask

  // one pulse on a clock pin; on_cp1 selects cp1_i, else cp0_i
  task automatic pulse(int d, bit on_cp1, string tag);
    if (on_cp1) cp1_i[d] = 1'b1; else cp0_drv[d] = 1'b1;
    #5;
    chk_all({tag, " R7 rise"});
    #5;
    if (on_cp1) cp1_i[d] = 1'b0; else cp0_drv[d] = 1'b0;
    if (!mr_i[d] && (bq_mode_i[d] == on_cp1)) advance(d);
    #5;
    chk_all(tag);
    #5;
  endtask

  task automatic clear_both(logic [1:0] mode);
    mr_i = 2'b11; #10;
    bq_mode_i = mode; cnt[0] = 0; cnt[1] = 0; #10;
    mr_i = 2'b00; #10;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int hi;
    #15;
    chk_all("R3 reset state");
    // clocks while held in clear
    pulse(0, 0, "R3 clk in clear");
    pulse(1, 1, "R3 clk in clear");
    clear_both(2'b10);
    chk_all("R3 after release");

    // d0 BCD, d1 bi-quinary
    for (int i = 0; i < 23; i++) begin
      pulse(0, 0, "R5 R1 bcd count");
      if (cnt[0] >= 8) chk("R5 q3 at 8/9", q_o[3], 1'b1);
    end
    pulse(0, 1, "R5 cp1 ignored");
    hi = 0;
    for (int i = 0; i < 30; i++) begin
      pulse(1, 1, "R6 R2 biq count");
      hi += int'(q_o[4]);
    end
    chk("R6 duty", 4'(hi), 4'd15 & 4'(15));
    pulse(1, 0, "R6 cp0 ignored");

    // independent clears (R4)
    pulse(1, 1, "R6 pre");
    pulse(1, 1, "R6 pre");
    mr_i[0] = 1'b1; cnt[0] = 0; #10;
    chk_all("R4 clear d0 only");
    mr_i[0] = 1'b0; #10;
    mr_i[1] = 1'b1; cnt[1] = 0; #10;
    pulse(1, 1, "R3 d1 clock held");
    chk_all("R4 clear d1 only");
    mr_i[1] = 1'b0; #10;

    // chain: d0 bi-quinary into d1 BCD
    clear_both(2'b01);
    chain = 1'b1; #10;
    for (int i = 0; i < 100; i++) begin
      pulse(0, 1, "R8 chain");
      if (i == 56) chk("R8 d1 after 57", q_o[7:4], 4'd5);
    end
    chk("R8 d0 back to 0", q_o[3:0], 4'd0);
    chk("R8 d1 back to 0", q_o[7:4], 4'd0);
    chain = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule